// File: doc/BRIEF.md
# Channel Attention Control Decoder

This block services attention events raised by a host processor against a shared control block in memory. Each attention makes the block fetch the 16-bit command word from the control block, zero that word in memory, and apply what it encodes. Acknowledge bits clear pending status flags. Two 3-bit control codes steer the command unit and the receive unit. One bit requests a soft reset. When the command unit is not suspended and no command list is held, the block then fetches a 32-bit list pointer from the control block. It finishes by writing a composed status word back to offset 0 and strobing a neighbouring command-list executor.

Attentions that arrive while one is being handled are counted and handled in turn, one full service each. Two event inputs from neighbouring units set the command-complete and frame-received flags, so all four flags share one status word.

Memory traffic uses a request channel with valid/ready and a read response channel with valid only:
- A request stays asserted with stable address, write enable and data until ready is seen high at a clock edge. The memory may hold ready low for any number of cycles.
- A write completes when it is accepted.
- A read completes on the single cycle in which the response valid is high.
- The block never has more than one read outstanding.
- The block does not issue a new request while it waits for a response.
- The response channel has no back-pressure.

Top module: `attn_ctrl_decoder`

## Requirements
- R1: A memory request holds valid, address, write enable and write data unchanged until accepted. Only 16-bit aligned addresses in the range base+0 to base+6 are used. A new request is never raised while a read response is pending.
- R2: Each service reads the command word at base+2. The next write after that read is a write of 0 to base+2, and it comes before the status write.
- R3: Command code bits 10:8 equal to 1 make the command unit active (state 2). Code 4 makes it suspended (state 1) and sets the command-unit-left-active flag (flag bit 1).
- R4: Receive code bits 6:4 equal to 1 or 2 make the receive unit ready (state 4). Code 3 or 4 makes it suspended (state 1) and sets the receiver-not-ready flag (flag bit 0).
- R5: Command bits 15:12 clear flag bits 3 (command complete), 2 (frame received), 1 and 0, bit for bit. The clears take effect before the sets of R3 and R4 within the same word.
- R6: Command bit 7 overrides the codes. The command unit becomes idle (state 0), the receive unit becomes suspended (state 1), all flags become 0 and the list pointer becomes null (all ones).
- R7: After applying the word, if the command unit is not suspended and the pointer is null, the pointer is loaded from base+4 (bits 15:0) and base+6 (bits 31:16), in that order.
- R8: The status word written to base+0 is {flags[3:0], command state[3:0], receive state[3:0], 4'b0000}.
- R9: Control codes other than those in R3 and R4 leave the respective unit state unchanged.
- R10: Each attention pulse is serviced exactly once, including pulses that arrive during a service. Up to 2^CNT_W-1 pulses can wait, and further pulses are dropped.
- R11: exec_start pulses for exactly one cycle, in the cycle after the status write is accepted, and only if the list pointer is not null.
- R12: After reset the command unit is idle (0), the receive unit is suspended (1), flags are 0, the pointer is null, and no request, strobe or busy indication is active.
- R13: cmd_done_evt sets flag bit 3 and frame_evt sets flag bit 2 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn_i | input | 1 | Attention pulse from host |
| scb_base_i | input | AW | Byte address of control block |
| cmd_done_evt_i | input | 1 | Sets command-complete flag |
| frame_evt_i | input | 1 | Sets frame-received flag |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request ready |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | AW | Request byte address |
| mem_req_wdata_o | output | 16 | Write data |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_rdata_i | input | 16 | Read response data |
| exec_start_o | output | 1 | Start strobe to list executor |
| cmd_ptr_o | output | 32 | Current command list pointer |
| cu_state_o | output | 4 | Command unit state |
| ru_state_o | output | 4 | Receive unit state |
| flags_o | output | 4 | Status flags |
| busy_o | output | 1 | Service in progress or queued |

## Verification
The hardest situations to reach are queueing and saturation of attentions, because a service normally completes long before the host can pulse again. The bench holds memory ready low so that the first service stalls on its command read. It then fires three pulses, and later ten pulses, back to back, and counts the status writes: three in the first case and seven in the second. Random memory back-pressure stretches each service by varying amounts. Command words mixing acknowledges, known and unknown codes and occasional soft resets drive the state through every transition.

// File: rtl/attn_pkg.sv
package attn_pkg;
  localparam int CW = 16;
  localparam int PW = 2 * CW;

  localparam logic [3:0] CU_IDLE   = 4'd0;
  localparam logic [3:0] CU_SUSP   = 4'd1;
  localparam logic [3:0] CU_ACTIVE = 4'd2;

  localparam logic [3:0] RU_IDLE   = 4'd0;
  localparam logic [3:0] RU_SUSP   = 4'd1;
  localparam logic [3:0] RU_READY  = 4'd4;

  localparam int FLG_CX  = 3;
  localparam int FLG_FR  = 2;
  localparam int FLG_CNA = 1;
  localparam int FLG_RNR = 0;

  localparam int OFF_STAT = 0;
  localparam int OFF_CMD  = 2;
  localparam int OFF_PLO  = 4;
  localparam int OFF_PHI  = 6;

  localparam logic [PW-1:0] PTR_NULL = '1;

  typedef struct packed {
    logic [3:0] ack;
    logic [2:0] cuc;
    logic       srst;
    logic [2:0] ruc;
  } cmd_fields_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CMD, S_WT_CMD, S_CLR, S_APPLY,
    S_RD_PLO, S_WT_PLO, S_RD_PHI, S_WT_PHI,
    S_PACK, S_WR_STAT, S_START
  } seq_state_e;
endpackage

// File: rtl/attn_pend_cnt.sv
module attn_pend_cnt #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pending
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  logic [CNT_W-1:0] cnt_q;
  logic inc_ok, dec_ok;

  assign dec_ok  = dec && (cnt_q != '0);
  assign inc_ok  = inc && ((cnt_q != MAXV) || dec_ok);
  assign pending = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc_ok && !dec_ok) cnt_q <= cnt_q + 1'b1;
    else if (dec_ok && !inc_ok) cnt_q <= cnt_q - 1'b1;
  end

  a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && inc && !dec) |=> (cnt_q == MAXV));
  a_r10_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && dec && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/attn_decode.sv
module attn_decode
  import attn_pkg::*;
(
  input  cmd_fields_t     cmd,
  input  logic [3:0]      cu_in,
  input  logic [3:0]      ru_in,
  input  logic [3:0]      flags_in,
  input  logic [PW-1:0]   ptr_in,
  output logic [3:0]      cu_out,
  output logic [3:0]      ru_out,
  output logic [3:0]      flags_out,
  output logic [PW-1:0]   ptr_out,
  output logic            need_load
);
  always_comb begin
    flags_out = flags_in & ~cmd.ack;
    cu_out    = cu_in;
    ru_out    = ru_in;
    ptr_out   = ptr_in;
    case (cmd.cuc)
      3'd1: cu_out = CU_ACTIVE;
      3'd4: begin
        cu_out = CU_SUSP;
        flags_out[FLG_CNA] = 1'b1;
      end
      default: ;
    endcase
    case (cmd.ruc)
      3'd1, 3'd2: ru_out = RU_READY;
      3'd3, 3'd4: begin
        ru_out = RU_SUSP;
        flags_out[FLG_RNR] = 1'b1;
      end
      default: ;
    endcase
    if (cmd.srst) begin
      cu_out    = CU_IDLE;
      ru_out    = RU_SUSP;
      flags_out = '0;
      ptr_out   = PTR_NULL;
    end
    need_load = (cu_out != CU_SUSP) && (ptr_out == PTR_NULL);
  end
endmodule

// File: rtl/attn_seq.sv
module attn_seq
  import attn_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pending,
  input  logic [AW-1:0] base,
  input  logic          load_needed,
  input  logic          ptr_valid,
  input  logic [CW-1:0] status_word,
  output cmd_fields_t   cmd,
  output logic          apply,
  output logic          lo_we,
  output logic          hi_we,
  output logic          start,
  output logic          done,
  output logic          idle,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [CW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [CW-1:0] mem_rsp_rdata_i
);
  seq_state_e st_q, st_d;
  cmd_fields_t cmd_q;
  logic [CW-1:0] stat_q;
  logic acc;

  assign acc = mem_req_valid_o && mem_req_ready_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:    if (pending) st_d = S_RD_CMD;
      S_RD_CMD:  if (acc) st_d = S_WT_CMD;
      S_WT_CMD:  if (mem_rsp_valid_i) st_d = S_CLR;
      S_CLR:     if (acc) st_d = S_APPLY;
      S_APPLY:   st_d = load_needed ? S_RD_PLO : S_PACK;
      S_RD_PLO:  if (acc) st_d = S_WT_PLO;
      S_WT_PLO:  if (mem_rsp_valid_i) st_d = S_RD_PHI;
      S_RD_PHI:  if (acc) st_d = S_WT_PHI;
      S_WT_PHI:  if (mem_rsp_valid_i) st_d = S_PACK;
      S_PACK:    st_d = S_WR_STAT;
      S_WR_STAT: if (acc) st_d = S_START;
      S_START:   st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cmd_q  <= '0;
      stat_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_WT_CMD && mem_rsp_valid_i) begin
        cmd_q.ack  <= mem_rsp_rdata_i[15:12];
        cmd_q.cuc  <= mem_rsp_rdata_i[10:8];
        cmd_q.srst <= mem_rsp_rdata_i[7];
        cmd_q.ruc  <= mem_rsp_rdata_i[6:4];
      end
      if (st_q == S_PACK) stat_q <= status_word;
    end
  end

  assign cmd   = cmd_q;
  assign apply = (st_q == S_APPLY);
  assign lo_we = (st_q == S_WT_PLO) && mem_rsp_valid_i;
  assign hi_we = (st_q == S_WT_PHI) && mem_rsp_valid_i;
  assign done  = (st_q == S_START);
  assign start = done && ptr_valid;
  assign idle  = (st_q == S_IDLE);

  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = base;
    mem_req_wdata_o = '0;
    case (st_q)
      S_RD_CMD: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = base + AW'(OFF_CMD);
      end
      S_CLR: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = base + AW'(OFF_CMD);
      end
      S_RD_PLO: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = base + AW'(OFF_PLO);
      end
      S_RD_PHI: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = base + AW'(OFF_PHI);
      end
      S_WR_STAT: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = base + AW'(OFF_STAT);
        mem_req_wdata_o = stat_q;
      end
      default: ;
    endcase
  end

  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
       && $stable(mem_req_wdata_o)));
  a_r1_no_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_ready_i && !mem_req_we_o) |=> !mem_req_valid_o);
  a_r11_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/attn_ctrl_decoder.sv
module attn_ctrl_decoder
  import attn_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          attn_i,
  input  logic [AW-1:0] scb_base_i,
  input  logic          cmd_done_evt_i,
  input  logic          frame_evt_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [15:0]   mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [15:0]   mem_rsp_rdata_i,
  output logic          exec_start_o,
  output logic [31:0]   cmd_ptr_o,
  output logic [3:0]    cu_state_o,
  output logic [3:0]    ru_state_o,
  output logic [3:0]    flags_o,
  output logic          busy_o
);
  logic [3:0]    cu_q, ru_q, flags_q;
  logic [PW-1:0] ptr_q;
  logic [3:0]    cu_n, ru_n, flags_n, evt;
  logic [PW-1:0] ptr_n;
  logic          need_load, pending, apply, lo_we, hi_we, start, done, idle;
  cmd_fields_t   cmd;
  logic [CW-1:0] status_word;

  assign evt = {cmd_done_evt_i, frame_evt_i, 2'b00};
  assign status_word = {flags_q, cu_q, ru_q, 4'b0000};

  attn_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(attn_i), .dec(done), .pending(pending)
  );

  attn_decode u_dec (
    .cmd(cmd), .cu_in(cu_q), .ru_in(ru_q), .flags_in(flags_q), .ptr_in(ptr_q),
    .cu_out(cu_n), .ru_out(ru_n), .flags_out(flags_n), .ptr_out(ptr_n),
    .need_load(need_load)
  );

  attn_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .base(scb_base_i),
    .load_needed(need_load), .ptr_valid(ptr_q != PTR_NULL),
    .status_word(status_word), .cmd(cmd), .apply(apply),
    .lo_we(lo_we), .hi_we(hi_we), .start(start), .done(done), .idle(idle),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_rdata_i(mem_rsp_rdata_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cu_q    <= CU_IDLE;
      ru_q    <= RU_SUSP;
      flags_q <= '0;
      ptr_q   <= PTR_NULL;
    end else begin
      if (apply) begin
        cu_q    <= cu_n;
        ru_q    <= ru_n;
        flags_q <= flags_n | evt;
        ptr_q   <= ptr_n;
      end else begin
        flags_q <= flags_q | evt;
        if (lo_we) ptr_q[CW-1:0]  <= mem_rsp_rdata_i;
        if (hi_we) ptr_q[PW-1:CW] <= mem_rsp_rdata_i;
      end
    end
  end

  assign exec_start_o = start;
  assign cmd_ptr_o    = ptr_q;
  assign cu_state_o   = cu_q;
  assign ru_state_o   = ru_q;
  assign flags_o      = flags_q;
  assign busy_o       = pending || !idle;

  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cmd.srst) |=> (cu_q == CU_IDLE && ru_q == RU_SUSP));
  a_r3_abort_cna: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !cmd.srst && cmd.cuc == 3'd4) |=> (flags_q[FLG_CNA] && cu_q == CU_SUSP));
  a_r4_ru_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !cmd.srst && (cmd.ruc == 3'd3 || cmd.ruc == 3'd4)) |=>
      (flags_q[FLG_RNR] && ru_q == RU_SUSP));
  a_r11_start_nonnull: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start_o |-> (cmd_ptr_o != PTR_NULL));
  a_r13_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_evt_i |=> flags_o[FLG_CX]);
endmodule

// File: tb/attn_ctrl_decoder_bench.sv
module attn_ctrl_decoder_bench;
  localparam logic [31:0] BASE = 32'h0000_0040;
  localparam logic [31:0] NULLP = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, attn, evt_cx, evt_fr;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic [31:0] mem_req_addr;
  logic [15:0] mem_req_wdata, mem_rsp_rdata;
  logic exec_start, busy;
  logic [31:0] cmd_ptr;
  logic [3:0] cu_state, ru_state, flags;

  attn_ctrl_decoder u_attn_ctrl_decoder (
    .clk(clk), .rst_n(rst_n), .attn_i(attn), .scb_base_i(BASE),
    .cmd_done_evt_i(evt_cx), .frame_evt_i(evt_fr),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_we_o(mem_req_we), .mem_req_addr_o(mem_req_addr),
    .mem_req_wdata_o(mem_req_wdata), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_rdata_i(mem_rsp_rdata), .exec_start_o(exec_start),
    .cmd_ptr_o(cmd_ptr), .cu_state_o(cu_state), .ru_state_o(ru_state),
    .flags_o(flags), .busy_o(busy)
  );

  int n_chk = 0, n_err = 0, n_stat = 0;
  bit finished = 0, hold_ready = 0, exp_clear = 0, expect_start = 0, exp_start_v = 0;
  bit pend_rd = 0;
  logic [15:0] pend_data = '0, last_cmd = '0;
  logic [15:0] bmem [0:3];
  logic [3:0] m_cu, m_ru, m_flags;
  logic [31:0] m_ptr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic model_apply(input logic [15:0] c);
    logic [3:0] f;
    f = m_flags & ~c[15:12];
    case (c[10:8])
      3'd1: m_cu = 4'd2;
      3'd4: begin m_cu = 4'd1; f[1] = 1'b1; end
      default: ;
    endcase
    case (c[6:4])
      3'd1, 3'd2: m_ru = 4'd4;
      3'd3, 3'd4: begin m_ru = 4'd1; f[0] = 1'b1; end
      default: ;
    endcase
    if (c[7]) begin
      m_cu = 4'd0; m_ru = 4'd1; f = 4'd0; m_ptr = NULLP;
    end
    m_flags = f;
    if (m_cu != 4'd1 && m_ptr == NULLP) m_ptr = {bmem[3], bmem[2]};
  endtask

  task automatic on_accept();
    logic [31:0] off;
    int idx;
    off = mem_req_addr - BASE;
    chk("R1 address in range and aligned", {31'd0, (off > 32'd6) || off[0]}, 32'd0);
    idx = int'(off[2:1]);
    if (!mem_req_we) begin
      if (idx == 1) begin last_cmd = bmem[1]; exp_clear = 1; end
      pend_data = bmem[idx];
      pend_rd = 1;
    end else if (idx == 1) begin
      chk("R2 clear data zero", {16'd0, mem_req_wdata}, 32'd0);
      chk("R2 clear follows command read", {31'd0, exp_clear}, 32'd1);
      exp_clear = 0;
      bmem[1] = mem_req_wdata;
    end else if (idx == 0) begin
      chk("R2 clear before status", {31'd0, exp_clear}, 32'd0);
      model_apply(last_cmd);
      n_stat++;
      chk(last_cmd[7] ? "R6 status cu" : (last_cmd[10:8] == 3'd1 || last_cmd[10:8] == 3'd4)
            ? "R3 status cu" : "R9 status cu unchanged", {28'd0, mem_req_wdata[11:8]}, {28'd0, m_cu});
      chk(last_cmd[7] ? "R6 status ru" : (last_cmd[6:4] != 3'd0 && last_cmd[6:4] <= 3'd4)
            ? "R4 status ru" : "R9 status ru unchanged", {28'd0, mem_req_wdata[7:4]}, {28'd0, m_ru});
      chk("R5 status flags", {28'd0, mem_req_wdata[15:12]}, {28'd0, m_flags});
      chk("R8 status low nibble", {28'd0, mem_req_wdata[3:0]}, 32'd0);
      chk("R8 status matches ports", {16'd0, mem_req_wdata},
          {16'd0, flags, cu_state, ru_state, 4'd0});
      chk("R7 list pointer", cmd_ptr, m_ptr);
      expect_start = 1;
      exp_start_v = (m_ptr != NULLP);
      bmem[0] = mem_req_wdata;
    end else begin
      chk("R1 write only to command or status", 32'd1, 32'd0);
    end
  endtask

  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = pend_rd;
      mem_rsp_rdata = pend_data;
      pend_rd = 0;
      if (expect_start) begin
        chk("R11 start strobe after status", {31'd0, exec_start}, {31'd0, exp_start_v});
        expect_start = 0;
      end else if (rst_n) begin
        chk("R11 no stray start", {31'd0, exec_start}, 32'd0);
      end
      mem_req_ready = hold_ready ? 1'b0 : ($urandom_range(0, 3) != 0);
      if (rst_n && mem_req_valid && mem_req_ready) on_accept();
    end
  end

  task automatic pulse_attn(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) attn = 1;
    end
    @(negedge clk) attn = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [15:0] c);
    bmem[1] = c;
    pulse_attn(1);
    wait_idle();
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    int base_stat;
    logic [15:0] c;
    void'($urandom(32'd4242));
    rst_n = 0; attn = 0; evt_cx = 0; evt_fr = 0;
    bmem[0] = 16'h0; bmem[1] = 16'h0; bmem[2] = 16'h1234; bmem[3] = 16'h0008;
    m_cu = 4'd0; m_ru = 4'd1; m_flags = 4'd0; m_ptr = NULLP;
    repeat (4) @(negedge clk);
    chk("R12 cu reset", {28'd0, cu_state}, 32'd0);
    chk("R12 ru reset", {28'd0, ru_state}, 32'd1);
    chk("R12 flags reset", {28'd0, flags}, 32'd0);
    chk("R12 ptr reset", cmd_ptr, NULLP);
    chk("R12 idle outputs", {29'd0, mem_req_valid, exec_start, busy}, 32'd0);
    rst_n = 1;

    run_cmd(16'h0110);
    chk("R3 cu active", {28'd0, cu_state}, 32'd2);
    chk("R4 ru ready", {28'd0, ru_state}, 32'd4);
    chk("R7 pointer loaded", cmd_ptr, 32'h0008_1234);

    @(negedge clk) begin evt_cx = 1; evt_fr = 1; end
    @(negedge clk) begin evt_cx = 0; evt_fr = 0; end
    m_flags = m_flags | 4'b1100;
    chk("R13 event flags set", {28'd0, flags}, {28'd0, m_flags});

    run_cmd(16'h4000);
    chk("R5 ack clears frame flag only", {28'd0, flags}, 32'h8);

    run_cmd(16'hB440);
    chk("R5 ack then abort sets cna/rnr", {28'd0, flags}, 32'h3);
    chk("R3 cu suspended", {28'd0, cu_state}, 32'd1);

    bmem[2] = 16'hFFFF; bmem[3] = 16'hFFFF;
    run_cmd(16'h0790);
    chk("R6 soft reset cu", {28'd0, cu_state}, 32'd0);
    chk("R6 soft reset flags", {28'd0, flags}, 32'd0);
    chk("R6 soft reset null ptr", cmd_ptr, NULLP);

    run_cmd(16'h0270);
    chk("R9 unknown codes keep cu", {28'd0, cu_state}, 32'd0);
    chk("R9 unknown codes keep ru", {28'd0, ru_state}, 32'd1);

    bmem[2] = 16'h00A0; bmem[3] = 16'h0000;
    base_stat = n_stat;
    bmem[1] = 16'h0120;
    hold_ready = 1;
    pulse_attn(3);
    hold_ready = 0;
    wait_idle();
    chk("R10 three queued attentions", n_stat - base_stat, 32'd3);

    base_stat = n_stat;
    bmem[1] = 16'h0000;
    hold_ready = 1;
    pulse_attn(10);
    hold_ready = 0;
    wait_idle();
    chk("R10 saturated queue", n_stat - base_stat, 32'd7);

    for (int k = 0; k < 60; k++) begin
      c = 16'($urandom);
      if ($urandom_range(0, 3) != 0) c[10:8] = ($urandom_range(0, 1) != 0) ? 3'd1 : 3'd4;
      if ($urandom_range(0, 3) != 0) c[6:4] = 3'($urandom_range(1, 4));
      c[7] = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) begin
        bmem[2] = 16'($urandom); bmem[3] = 16'($urandom);
      end
      if ($urandom_range(0, 2) == 0) begin
        @(negedge clk) evt_cx = 1;
        @(negedge clk) evt_cx = 0;
        m_flags[3] = 1'b1;
      end
      run_cmd(c);
    end
    report();
  end
endmodule